// File: doc/BRIEF.md
# Polar LLR F/G Processing Element Array

This block is one arithmetic stage of a successive cancellation polar decoder. It takes a vector of `M` log-likelihood ratios held in sign-magnitude form, pairs neighbouring elements, and runs one min-sum check unit (F) and one variable-combining unit (G) on each pair. Every G unit also receives one hard-decision feedback bit from the partial-sum logic of the decoder.

The F unit gives a result whose sign is the product of the two input signs and whose magnitude is the smaller of the two input magnitudes. The G unit adds or subtracts the two values. It works out both the sum and the difference in two's complement at all times. The feedback bit only selects between them at the end, so a late feedback bit does not lengthen the path. After each unit, the result is cut down to a narrower output width by saturating the magnitude. The requantized results can pass through one output register stage, which is fitted at elaboration time.

An instance is built once for each stage of an unrolled decoder. The input width, output width and vector length are set per instance to match the precision plan of that code segment.

Top module: `polar_fg_stage`

## Requirements
- R1: For pair j, the F output has magnitude min(|a|,|b|) and sign sign(a) XOR sign(b). The result is then requantized as in R5 and R6.
- R2: When hardDec[j] is 0, the G output of pair j equals b + a. The result is then saturated and requantized as in R4 to R6.
- R3: When hardDec[j] is 1, the G output of pair j equals b − a. The result is then saturated and requantized as in R4 to R6.
- R4: A G result whose magnitude exceeds 2^(Q−1)−1 saturates to that magnitude and keeps its sign.
- R5: Each output is QOUT bits of sign-magnitude: the sign is in the MSB and the magnitude in the low QOUT−1 bits. A magnitude above 2^(QOUT−1)−1 saturates to that value and keeps its sign.
- R6: No output ever carries a set sign bit with a zero magnitude. This holds even when an input is a negative zero, or when the G sum or difference cancels to zero.
- R7: Element i of the input vector occupies llrIn[i*Q +: Q]. Pair j takes a = element 2j and b = element 2j+1. The results of pair j appear at fOut[j*QOUT +: QOUT] and gOut[j*QOUT +: QOUT].
- R8: With OUT_REG=1, the outputs show the results for the inputs that were present at the previous rising clock edge. A synchronous active-high rst clears both outputs to zero at the next edge.
- R9: hardDec[j] changes only the G output of pair j. The F outputs and the other pairs are not affected by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| llrIn | input | M*Q | Packed vector of M sign-magnitude input LLRs |
| hardDec | input | M/2 | Hard-decision feedback bit for each pair's G unit |
| fOut | output | (M/2)*QOUT | Requantized F results, one per pair |
| gOut | output | (M/2)*QOUT | Requantized G results, one per pair |

## Verification
On every cycle, the checker compares the F magnitude and F sign of each pair against the inputs registered on the previous edge. It also checks that no lane ever emits a negative zero, that a reset cycle leaves both outputs at zero, and that a G result built from two positive inputs with a zero feedback bit stays positive.

Some behaviours are shown only by the bench scenarios, which use a behavioural integer model. These are the exact G arithmetic under both feedback values, the two saturation steps at their limits, cancellation to zero, the mapping of pairs to lanes, and the independence of F from the feedback bit.

// File: rtl/polar_fg_pkg.sv
package polar_fg_pkg;
  typedef struct packed {
    logic clear;
    logic load;
  } stageStrobes_t;
endpackage

// File: rtl/polar_sm_requant.sv
module polar_sm_requant #(
  parameter int IN_W  = 5,
  parameter int OUT_W = 4
) (
  input  logic [IN_W-1:0]  smIn,
  output logic [OUT_W-1:0] smOut
);
  localparam int IN_MW  = IN_W - 1;
  localparam int OUT_MW = OUT_W - 1;

  logic             inSign;
  logic [IN_MW-1:0] inMag;
  logic [OUT_MW-1:0] outMag;

  assign inSign = smIn[IN_W-1];
  assign inMag  = smIn[IN_MW-1:0];

  generate
    if (OUT_W == IN_W) begin : g_pass
      assign outMag = inMag;
    end else begin : g_cut
      logic highSet;
      assign highSet = |inMag[IN_MW-1:OUT_MW];
      assign outMag  = highSet ? {OUT_MW{1'b1}} : inMag[OUT_MW-1:0];
    end
  endgenerate

  assign smOut = {inSign && (outMag != '0), outMag};
endmodule

// File: rtl/polar_fg_lane.sv
module polar_fg_lane #(
  parameter int Q    = 5,
  parameter int QOUT = 4
) (
  input  logic [Q-1:0]    llrA,
  input  logic [Q-1:0]    llrB,
  input  logic            hardBit,
  output logic [QOUT-1:0] fRes,
  output logic [QOUT-1:0] gRes
);
  localparam int MW      = Q - 1;
  localparam int SAT_LIM = (1 << MW) - 1;

  logic          aSign, bSign;
  logic [MW-1:0] aMag, bMag;

  assign aSign = llrA[Q-1];
  assign bSign = llrB[Q-1];
  assign aMag  = llrA[MW-1:0];
  assign bMag  = llrB[MW-1:0];

  // F unit: compare-and-select on magnitudes, XOR on signs
  logic [MW-1:0] fMag;
  logic [Q-1:0]  fFull;
  assign fMag  = (aMag < bMag) ? aMag : bMag;
  assign fFull = {(aSign ^ bSign) && (fMag != '0), fMag};

  // G unit: both candidates precomputed, feedback bit is a late select
  logic signed [Q:0] aTwos, bTwos, sumVal, diffVal, pickVal;
  logic        [Q:0] absVal;
  logic              pickNeg;
  logic     [MW-1:0] gMag;
  logic      [Q-1:0] gFull;

  assign aTwos   = aSign ? -$signed({2'b00, aMag}) : $signed({2'b00, aMag});
  assign bTwos   = bSign ? -$signed({2'b00, bMag}) : $signed({2'b00, bMag});
  assign sumVal  = bTwos + aTwos;
  assign diffVal = bTwos - aTwos;
  assign pickVal = hardBit ? diffVal : sumVal;
  assign pickNeg = pickVal[Q];
  assign absVal  = pickNeg ? $unsigned(-pickVal) : $unsigned(pickVal);
  assign gMag    = (absVal > (Q+1)'(SAT_LIM)) ? MW'(SAT_LIM) : absVal[MW-1:0];
  assign gFull   = {pickNeg && (gMag != '0), gMag};

  polar_sm_requant #(.IN_W(Q), .OUT_W(QOUT)) i_reqF (.smIn(fFull), .smOut(fRes));
  polar_sm_requant #(.IN_W(Q), .OUT_W(QOUT)) i_reqG (.smIn(gFull), .smOut(gRes));
endmodule

// File: rtl/polar_fg_ctrl.sv
module polar_fg_ctrl
  import polar_fg_pkg::*;
(
  input  logic          rst,
  output stageStrobes_t strobes
);
  always_comb begin
    strobes.clear = rst;
    strobes.load  = !rst;
  end
endmodule

// File: rtl/polar_fg_datapath.sv
module polar_fg_datapath
  import polar_fg_pkg::*;
#(
  parameter int M       = 8,
  parameter int Q       = 5,
  parameter int QOUT    = 4,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                   clk,
  input  stageStrobes_t          strobes,
  input  logic [M*Q-1:0]         llrIn,
  input  logic [M/2-1:0]         hardDec,
  output logic [(M/2)*QOUT-1:0]  fOut,
  output logic [(M/2)*QOUT-1:0]  gOut
);
  localparam int HALF = M / 2;
  localparam int OW   = HALF * QOUT;

  logic [OW-1:0] fNext, gNext;

  for (genvar j = 0; j < HALF; j++) begin : g_lane
    polar_fg_lane #(.Q(Q), .QOUT(QOUT)) i_lane (
      .llrA    (llrIn[(2*j)*Q +: Q]),
      .llrB    (llrIn[(2*j+1)*Q +: Q]),
      .hardBit (hardDec[j]),
      .fRes    (fNext[j*QOUT +: QOUT]),
      .gRes    (gNext[j*QOUT +: QOUT])
    );
  end

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (strobes.clear) begin
          fOut <= '0;
          gOut <= '0;
        end else if (strobes.load) begin
          fOut <= fNext;
          gOut <= gNext;
        end
      end
    end else begin : g_comb
      assign fOut = fNext;
      assign gOut = gNext;
    end
  endgenerate
endmodule

// File: rtl/polar_fg_stage.sv
module polar_fg_stage
  import polar_fg_pkg::*;
#(
  parameter int M       = 8,
  parameter int Q       = 5,
  parameter int QOUT    = 4,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [M*Q-1:0]        llrIn,
  input  logic [M/2-1:0]        hardDec,
  output logic [(M/2)*QOUT-1:0] fOut,
  output logic [(M/2)*QOUT-1:0] gOut
);
  stageStrobes_t strobes;

  polar_fg_ctrl i_ctrl (.rst(rst), .strobes(strobes));

  polar_fg_datapath #(.M(M), .Q(Q), .QOUT(QOUT), .OUT_REG(OUT_REG)) i_dp (
    .clk     (clk),
    .strobes (strobes),
    .llrIn   (llrIn),
    .hardDec (hardDec),
    .fOut    (fOut),
    .gOut    (gOut)
  );
endmodule

// File: rtl/polar_fg_stage_chk.sv
module polar_fg_stage_chk #(
  parameter int M       = 8,
  parameter int Q       = 5,
  parameter int QOUT    = 4,
  parameter bit OUT_REG = 1'b1
) (
  input logic                  clk,
  input logic                  rst,
  input logic [M*Q-1:0]        llrIn,
  input logic [M/2-1:0]        hardDec,
  input logic [(M/2)*QOUT-1:0] fOut,
  input logic [(M/2)*QOUT-1:0] gOut
);
  localparam int HALF = M / 2;
  localparam int MW   = Q - 1;
  localparam int OMW  = QOUT - 1;
  localparam int OMAX = (1 << OMW) - 1;

  logic           pastRst;
  logic [M*Q-1:0] prevLlr;
  logic [HALF-1:0] prevHd;

  always_ff @(posedge clk) begin
    pastRst <= rst;
    prevLlr <= llrIn;
    prevHd  <= hardDec;
  end

  for (genvar j = 0; j < HALF; j++) begin : g_chk
    logic [QOUT-1:0] fL, gL;
    logic [MW-1:0]   pa, pb, pMin;
    logic            sa, sb;
    logic [OMW-1:0]  expMag;
    assign fL     = fOut[j*QOUT +: QOUT];
    assign gL     = gOut[j*QOUT +: QOUT];
    assign pa     = prevLlr[(2*j)*Q +: MW];
    assign pb     = prevLlr[(2*j+1)*Q +: MW];
    assign sa     = prevLlr[(2*j)*Q + MW];
    assign sb     = prevLlr[(2*j+1)*Q + MW];
    assign pMin   = (pa < pb) ? pa : pb;
    assign expMag = (32'(pMin) > OMAX) ? OMW'(OMAX) : pMin[OMW-1:0];

    assert_no_negzero_R6: assert property (@(posedge clk) disable iff (rst)
      (fL != {1'b1, {OMW{1'b0}}}) && (gL != {1'b1, {OMW{1'b0}}}));

    if (OUT_REG) begin : g_timed
      assert_reset_clear_R8: assert property (@(posedge clk) disable iff (rst)
        pastRst |-> (fL == '0) && (gL == '0));
      assert_f_mag_R1: assert property (@(posedge clk) disable iff (rst)
        !pastRst |-> fL[OMW-1:0] == expMag);
      assert_f_sign_R1: assert property (@(posedge clk) disable iff (rst)
        (!pastRst && fL[OMW-1:0] != '0) |-> fL[QOUT-1] == (sa ^ sb));
      assert_g_positive_R2: assert property (@(posedge clk) disable iff (rst)
        (!pastRst && !prevHd[j] && !sa && !sb) |-> !gL[QOUT-1]);
    end
  end
endmodule

bind polar_fg_stage polar_fg_stage_chk #(.M(M), .Q(Q), .QOUT(QOUT), .OUT_REG(OUT_REG)) i_chk (
  .clk(clk), .rst(rst), .llrIn(llrIn), .hardDec(hardDec), .fOut(fOut), .gOut(gOut)
);

// File: tb/test_polar_fg_stage.sv
module test_polar_fg_stage;
  localparam int PERIOD = 10;
  localparam int M      = 8;
  localparam int Q      = 5;
  localparam int QOUT   = 4;
  localparam int HALF   = M / 2;
  localparam int IMAX   = (1 << (Q - 1)) - 1;
  localparam int OMAX   = (1 << (QOUT - 1)) - 1;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic [M*Q-1:0]       llrIn = '0;
  logic [HALF-1:0]      hardDec = '0;
  logic [HALF*QOUT-1:0] fOut, gOut;

  int checks = 0;
  int fails  = 0;
  string fTag = "R8";
  string gTag = "R8";

  logic [QOUT-1:0] expF [HALF];
  logic [QOUT-1:0] expG [HALF];
  int elem [M];
  logic [HALF-1:0] nextHd;

  always #(PERIOD/2) clk = ~clk;

  polar_fg_stage #(.M(M), .Q(Q), .QOUT(QOUT), .OUT_REG(1'b1)) i_polar_fg_stage (
    .clk(clk), .rst(rst), .llrIn(llrIn), .hardDec(hardDec), .fOut(fOut), .gOut(gOut)
  );

  function automatic logic [QOUT-1:0] enc(int v);
    int m = (v < 0) ? -v : v;
    if (m > OMAX) m = OMAX;
    return {(v < 0) && (m != 0), (QOUT-1)'(m)};
  endfunction

  function automatic logic [Q-1:0] toSm(int v, bit negZero);
    int m = (v < 0) ? -v : v;
    return {(v < 0) || negZero, (Q-1)'(m)};
  endfunction

  task automatic cycle(input logic r);
    @(negedge clk);
    for (int j = 0; j < HALF; j++) begin
      checks++;
      if (fOut[j*QOUT +: QOUT] !== expF[j]) begin
        fails++;
        $display("FAIL %s lane %0d F: actual %b expected %b", fTag, j, fOut[j*QOUT +: QOUT], expF[j]);
      end
      checks++;
      if (gOut[j*QOUT +: QOUT] !== expG[j]) begin
        fails++;
        $display("FAIL %s lane %0d G: actual %b expected %b", gTag, j, gOut[j*QOUT +: QOUT], expG[j]);
      end
    end
    rst = r;
    hardDec = nextHd;
    for (int i = 0; i < M; i++) llrIn[i*Q +: Q] = toSm(elem[i], 1'b0);
    for (int j = 0; j < HALF; j++) begin
      int a = elem[2*j];
      int b = elem[2*j+1];
      int ma = (a < 0) ? -a : a;
      int mb = (b < 0) ? -b : b;
      int mn = (ma < mb) ? ma : mb;
      int gv = hardDec[j] ? (b - a) : (b + a);
      int fv = (((a < 0) != (b < 0)) ? -mn : mn);
      if (gv > IMAX) gv = IMAX;
      if (gv < -IMAX) gv = -IMAX;
      expF[j] = r ? '0 : enc(fv);
      expG[j] = r ? '0 : enc(gv);
    end
  endtask

  task automatic randFill();
    for (int i = 0; i < M; i++) elem[i] = int'($urandom_range(2*IMAX)) - IMAX;
  endtask

  initial begin
    #(PERIOD*100000);
    fails++;
    checks++;
    $display("FAIL watchdog expired: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int j = 0; j < HALF; j++) begin expF[j] = '0; expG[j] = '0; end
    // R8: reset holds outputs at zero
    nextHd = '1;
    randFill();
    for (int k = 0; k < 3; k++) cycle(1'b1);

    // R1 and R2: random inputs, zero feedback
    fTag = "R1"; gTag = "R2"; nextHd = '0;
    for (int k = 0; k < 20; k++) begin randFill(); cycle(1'b0); end

    // R3: random inputs, feedback set
    gTag = "R3"; nextHd = '1;
    for (int k = 0; k < 20; k++) begin randFill(); cycle(1'b0); end

    // R4 and R5: extreme magnitudes drive both saturation steps
    fTag = "R5"; gTag = "R4";
    for (int k = 0; k < 4; k++) begin
      for (int j = 0; j < HALF; j++) begin
        elem[2*j]   = (k[0]) ? -IMAX : IMAX;
        elem[2*j+1] = (k[1]) ? -(IMAX - j) : (IMAX - j);
      end
      nextHd = HALF'(k * 5);
      cycle(1'b0);
    end

    // R6: negative zero inputs and cancellation to zero
    fTag = "R6"; gTag = "R6";
    for (int j = 0; j < HALF; j++) begin elem[2*j] = j + 1; elem[2*j+1] = j + 1; end
    nextHd = '1;
    cycle(1'b0);
    for (int j = 0; j < HALF; j++) begin elem[2*j] = -(j + 2); elem[2*j+1] = j + 2; end
    nextHd = '0;
    cycle(1'b0);
    @(negedge clk);
    llrIn = '0;
    for (int i = 0; i < M; i++) llrIn[i*Q +: Q] = toSm(0, 1'b1);
    for (int j = 0; j < HALF; j++) begin expF[j] = '0; expG[j] = '0; end
    for (int i = 0; i < M; i++) elem[i] = 0;
    cycle(1'b0);

    // R7: distinct per-lane values reveal the pair and lane mapping
    fTag = "R7"; gTag = "R7";
    for (int j = 0; j < HALF; j++) begin elem[2*j] = j + 1; elem[2*j+1] = -(2*j + 1); end
    nextHd = HALF'(4'b0101);
    cycle(1'b0);
    nextHd = HALF'(4'b0110);
    cycle(1'b0);

    // R9: same LLRs, feedback toggling changes only G
    fTag = "R9"; gTag = "R9";
    randFill();
    for (int k = 0; k < 6; k++) begin nextHd = HALF'(k); cycle(1'b0); end

    // R8: reset in mid-run, then resume
    fTag = "R8"; gTag = "R8";
    randFill();
    cycle(1'b1);
    cycle(1'b0);
    fTag = "R1"; gTag = "R2"; nextHd = '0;
    randFill();
    cycle(1'b0);
    cycle(1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule